// File: doc/BRIEF.md
# Tuning Synthesizer Two-Wire Register Slave

This block is the serial control front end of a frequency-synthesizer tuner. It acts as a two-wire (I2C) slave and keeps three output registers: a 15-bit divider ratio, a 7-bit control word and a 4-bit port word. The synthesizer datapath reads these registers directly. SCL and SDA are sampled with the system clock through a synchronizer. SDA is driven open-drain: the block only ever pulls the line low.

A write transfer has no register pointer. The top bit of each data byte says whether the byte opens a divider pair or a control pair. The byte after it is always taken as the partner byte of that pair. Pairs may follow one another in any order until STOP. A read transfer returns one status byte for each master acknowledge. The status byte holds a power-on flag kept by the block, plus a lock flag, three port levels and a 3-bit converter code, all taken from inputs.

Of the four slave addresses, one is always answered. One of the other three is also answered, chosen by a 2-bit select input. The analog sensing that produces that code lies outside the block.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The address byte is a 7-bit address followed by a read/write bit (1 = read). The slave matches address 7'b11000_ss only when ss is 2'b01 or ss equals `addr_sel`. These are write bytes 192, 194, 196 and 198. Any other address gets no acknowledge, and the data bytes that follow change no register.
- R2: After a matching address byte, and after every write data byte of a matched transfer, the slave holds SDA low for the whole ninth clock.
- R3: A data byte that starts a pair and has bit 7 = 0 stores its bits 6..0 as divider bits 14..8. The next byte supplies divider bits 7..0. The `divider` output changes only when that second byte completes.
- R4: A data byte that starts a pair and has bit 7 = 1 loads its bits 6..0 into `ctrl` when the byte completes. The next byte is always treated as the port byte, whatever its bit 7. Its bits 3..0 load `ports_out` as {P6, P2, P1, P0}, and its bits 7..4 are ignored.
- R5: Divider pairs and control pairs may come in any order, any number of times, in one transfer. START or STOP clears a half-finished pair, so the next data byte starts a new pair.
- R6: In a read, the status byte {por, lock_i, port_in[2:0], adc_code[2:0]} goes out MSB first. A master ACK (SDA low in the ninth clock) brings a freshly sampled status byte. A NACK makes the slave release SDA.
- R7: The power-on flag is 1 after reset and after any cycle with `por_event` high. A STOP that ends a transfer with a matched read address clears it. A STOP that ends a write transfer leaves it unchanged.
- R8: After reset, `divider`, `ctrl` and `ports_out` are all zero and SDA is released.
- R9: A START seen in the middle of any byte drops that byte and releases SDA. The slave then expects a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 2 | Selects the extra answered address |
| por_event | input | 1 | Low-supply pulse; sets the power-on flag |
| lock_i | input | 1 | Loop lock indication for status |
| port_in | input | 3 | Port pin levels for status |
| adc_code | input | 3 | Converter code for status |
| sda_oe | output | 1 | 1 pulls SDA low |
| divider | output | 15 | Divider ratio register |
| ctrl | output | 7 | Control register |
| ports_out | output | 4 | Port register {P6, P2, P1, P0} |

## Verification
The hardest state to reach is a pair left half-finished when the bus event arrives. One case is a divider first byte followed by STOP. The other is a START that lands a few bits into a data byte. A correct slave must then take the next byte as the start of a new pair. The stimulus sends exactly those partial sequences, then sends a byte whose pair type differs from the abandoned one. Any wrong pairing would then show up on `divider` or `ctrl`. The address match is swept over all four select codes and a block of neighbouring address bytes, and the expected ACK comes from the address arithmetic.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_WAIT,
        S_ACK_DRV,
        S_WR,
        S_RD,
        S_RD_ACK,
        S_RD_NEXT
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_DIV2,
        PH_CB2
    } pair_ph_e;

endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_last;
        logic              sda_last;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_now;

    assign scl_now = sync_q.scl[STAGES-1];
    assign sda_bit = sync_q.sda[STAGES-1];

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl      = {sync_q.scl[STAGES-2:0], scl_i};
        sync_d.sda      = {sync_q.sda[STAGES-2:0], sda_i};
        sync_d.scl_last = scl_now;
        sync_d.sda_last = sda_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_rise  = scl_now & ~sync_q.scl_last;
    assign scl_fall  = ~scl_now & sync_q.scl_last;
    assign start_det = scl_now & sync_q.scl_last & sync_q.sda_last & ~sda_bit;
    assign stop_det  = scl_now & sync_q.scl_last & ~sync_q.sda_last & sda_bit;

endmodule

// File: rtl/tuner_i2c_addr_match.sv
module tuner_i2c_addr_match #(
    parameter logic [6:0] ADDR_BASE = 7'h60,
    parameter int         FIXED_SEL = 1
) (
    input  logic [6:0] addr7,
    input  logic [1:0] addr_sel,
    output logic       hit
);

    localparam int NUM_CAND = 4;

    logic [NUM_CAND-1:0] cand_hit;

    for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
        localparam logic [6:0] CAND = ADDR_BASE | 7'(k);
        logic enabled;
        assign enabled     = (k == FIXED_SEL) || (addr_sel == 2'(k));
        assign cand_hit[k] = enabled && (addr7 == CAND);
    end

    assign hit = |cand_hit;

endmodule

// File: rtl/tuner_i2c_regbank.sv
module tuner_i2c_regbank #(
    parameter int DIV_W  = 15,
    parameter int CTL_W  = 7,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_val,
    input  logic              port_we,
    input  logic [PORT_W-1:0] port_val,
    output logic [DIV_W-1:0]  divider,
    output logic [CTL_W-1:0]  ctrl,
    output logic [PORT_W-1:0] ports_out
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [CTL_W-1:0]  ctl;
        logic [PORT_W-1:0] prt;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (div_we)  bank_d.div = div_val;
        if (ctl_we)  bank_d.ctl = ctl_val;
        if (port_we) bank_d.prt = port_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign divider   = bank_q.div;
    assign ctrl      = bank_q.ctl;
    assign ports_out = bank_q.prt;

endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave #(
    parameter int         DIV_W       = 15,
    parameter int         CTL_W       = 7,
    parameter int         PORT_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_BASE   = 7'h60,
    parameter int         FIXED_SEL   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    input  logic              por_event,
    input  logic              lock_i,
    input  logic [2:0]        port_in,
    input  logic [2:0]        adc_code,
    output logic              sda_oe,
    output logic [DIV_W-1:0]  divider,
    output logic [CTL_W-1:0]  ctrl,
    output logic [PORT_W-1:0] ports_out
);

    import tuner_i2c_pkg::*;

    localparam int HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        bus_st_e           st;
        pair_ph_e          ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [HI_W-1:0]   hi;
        logic              rw;
        logic              rd_seen;
        logic              oe;
        logic              por;
    } slv_t;

    slv_t slv_d, slv_q;

    logic              sda_bit, scl_rise, scl_fall, start_det, stop_det;
    logic              addr_hit;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] status;
    logic              div_we, ctl_we, port_we;
    logic              por_flag, bus_idle;

    tuner_i2c_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_bit   (sda_bit),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tuner_i2c_addr_match #(
        .ADDR_BASE (ADDR_BASE),
        .FIXED_SEL (FIXED_SEL)
    ) u_match (
        .addr7    (slv_q.sh[6:0]),
        .addr_sel (addr_sel),
        .hit      (addr_hit)
    );

    assign byte_in = {slv_q.sh[BYTE_W-2:0], sda_bit};
    assign status  = {slv_q.por, lock_i, port_in, adc_code};

    always_comb begin
        slv_d   = slv_q;
        div_we  = 1'b0;
        ctl_we  = 1'b0;
        port_we = 1'b0;

        if (start_det) begin
            slv_d.st      = S_ADDR;
            slv_d.cnt     = '0;
            slv_d.oe      = 1'b0;
            slv_d.ph      = PH_FIRST;
            slv_d.rd_seen = 1'b0;
        end else if (stop_det) begin
            if (slv_q.rd_seen) slv_d.por = 1'b0;
            slv_d.st      = S_IDLE;
            slv_d.oe      = 1'b0;
            slv_d.ph      = PH_FIRST;
            slv_d.rd_seen = 1'b0;
        end else begin
            case (slv_q.st)
                S_ADDR: begin
                    if (scl_rise) begin
                        slv_d.sh  = byte_in;
                        slv_d.cnt = slv_q.cnt + 1'b1;
                        if (slv_q.cnt == CNT_W'(BYTE_W - 1)) begin
                            if (addr_hit) begin
                                slv_d.rw = sda_bit;
                                slv_d.st = S_ACK_WAIT;
                                if (sda_bit) slv_d.rd_seen = 1'b1;
                            end else begin
                                slv_d.st = S_IDLE;
                            end
                        end
                    end
                end
                S_ACK_WAIT: begin
                    if (scl_fall) begin
                        slv_d.oe = 1'b1;
                        slv_d.st = S_ACK_DRV;
                    end
                end
                S_ACK_DRV: begin
                    if (scl_fall) begin
                        if (slv_q.rw) begin
                            slv_d.sh  = {status[BYTE_W-2:0], 1'b0};
                            slv_d.oe  = ~status[BYTE_W-1];
                            slv_d.cnt = CNT_W'(1);
                            slv_d.st  = S_RD;
                        end else begin
                            slv_d.oe  = 1'b0;
                            slv_d.cnt = '0;
                            slv_d.st  = S_WR;
                        end
                    end
                end
                S_WR: begin
                    if (scl_rise) begin
                        slv_d.sh  = byte_in;
                        slv_d.cnt = slv_q.cnt + 1'b1;
                        if (slv_q.cnt == CNT_W'(BYTE_W - 1)) begin
                            slv_d.st = S_ACK_WAIT;
                            case (slv_q.ph)
                                PH_FIRST: begin
                                    if (byte_in[BYTE_W-1]) begin
                                        ctl_we   = 1'b1;
                                        slv_d.ph = PH_CB2;
                                    end else begin
                                        slv_d.hi = byte_in[HI_W-1:0];
                                        slv_d.ph = PH_DIV2;
                                    end
                                end
                                PH_DIV2: begin
                                    div_we   = 1'b1;
                                    slv_d.ph = PH_FIRST;
                                end
                                PH_CB2: begin
                                    port_we  = 1'b1;
                                    slv_d.ph = PH_FIRST;
                                end
                                default: slv_d.ph = PH_FIRST;
                            endcase
                        end
                    end
                end
                S_RD: begin
                    if (scl_fall) begin
                        if (slv_q.cnt == CNT_W'(BYTE_W)) begin
                            slv_d.oe = 1'b0;
                            slv_d.st = S_RD_ACK;
                        end else begin
                            slv_d.oe  = ~slv_q.sh[BYTE_W-1];
                            slv_d.sh  = {slv_q.sh[BYTE_W-2:0], 1'b0};
                            slv_d.cnt = slv_q.cnt + 1'b1;
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        slv_d.st = sda_bit ? S_IDLE : S_RD_NEXT;
                    end
                end
                S_RD_NEXT: begin
                    if (scl_fall) begin
                        slv_d.sh  = {status[BYTE_W-2:0], 1'b0};
                        slv_d.oe  = ~status[BYTE_W-1];
                        slv_d.cnt = CNT_W'(1);
                        slv_d.st  = S_RD;
                    end
                end
                default: slv_d.st = S_IDLE;
            endcase
        end

        if (por_event) slv_d.por = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q         <= '0;
            slv_q.st      <= S_IDLE;
            slv_q.ph      <= PH_FIRST;
            slv_q.por     <= 1'b1;
        end else begin
            slv_q <= slv_d;
        end
    end

    tuner_i2c_regbank #(
        .DIV_W  (DIV_W),
        .CTL_W  (CTL_W),
        .PORT_W (PORT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_we    (div_we),
        .div_val   ({slv_q.hi, byte_in}),
        .ctl_we    (ctl_we),
        .ctl_val   (byte_in[CTL_W-1:0]),
        .port_we   (port_we),
        .port_val  (byte_in[PORT_W-1:0]),
        .divider   (divider),
        .ctrl      (ctrl),
        .ports_out (ports_out)
    );

    assign sda_oe   = slv_q.oe;
    assign por_flag = slv_q.por;
    assign bus_idle = (slv_q.st == S_IDLE);

endmodule

// File: rtl/tuner_i2c_slave_chk.sv
module tuner_i2c_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_det,
    input logic        sda_oe,
    input logic        div_we,
    input logic        ctl_we,
    input logic        port_we,
    input logic        por_event,
    input logic        por_flag,
    input logic        bus_idle,
    input logic [14:0] divider,
    input logic [6:0]  ctrl
);

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R3
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divider) |-> $past(div_we));

    // R4
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(ctl_we));

    // R5
    one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div_we, ctl_we, port_we}));

    // R7
    por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_event |=> por_flag);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !sda_oe);

endmodule

bind tuner_i2c_slave tuner_i2c_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .sda_oe    (sda_oe),
    .div_we    (div_we),
    .ctl_we    (ctl_we),
    .port_we   (port_we),
    .por_event (por_event),
    .por_flag  (por_flag),
    .bus_idle  (bus_idle),
    .divider   (divider),
    .ctrl      (ctrl)
);

// File: tb/tuner_i2c_slave_test.sv
`timescale 1ns/1ps
module tuner_i2c_slave_test;

    localparam int Q  = 10;
    localparam int WD = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'd0;
    logic        por_event = 1'b0;
    logic        lock_i = 1'b0;
    logic [2:0]  port_in = 3'd0;
    logic [2:0]  adc_code = 3'd0;
    logic        sda_oe;
    logic [14:0] divider;
    logic [6:0]  ctrl;
    logic [3:0]  ports_out;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [14:0] exp_div = '0;
    logic [6:0]  exp_ctl = '0;
    logic [3:0]  exp_prt = '0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tuner_i2c_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .addr_sel  (addr_sel),
        .por_event (por_event),
        .lock_i    (lock_i),
        .port_in   (port_in),
        .adc_code  (adc_code),
        .sda_oe    (sda_oe),
        .divider   (divider),
        .ctrl      (ctrl),
        .ports_out (ports_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; half();
        scl_m = 1'b1; half(); half();
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        ack = (sda_line == 1'b0);
        half();
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input bit m_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; half();
            scl_m = 1'b1; half();
            d[i] = sda_line;
            half();
            scl_m = 1'b0;
        end
        put_bit(!m_ack);
        sda_m = 1'b1;
    endtask

    task automatic check_regs(input string req);
        chk(divider == exp_div, req, divider, exp_div);
        chk(ctrl == exp_ctl, req, ctrl, exp_ctl);
        chk(ports_out == exp_prt, req, ports_out, exp_prt);
    endtask

    task automatic wr_div_pair(input logic [14:0] d, input bit expect_ack);
        bit a1, a2;
        write_byte({1'b0, d[14:8]}, a1);
        write_byte(d[7:0], a2);
        if (expect_ack) begin
            chk(a1 && a2, "R2 data ack", {a1, a2}, 3);
            exp_div = d;
        end
    endtask

    task automatic read_status(input bit por_exp, input string req);
        bit a;
        logic [7:0] s;
        logic [7:0] e;
        i2c_start();
        write_byte(8'hC3, a);
        chk(a, "R1 read address ack", a, 1);
        e = {por_exp, lock_i, port_in, adc_code};
        read_byte(1'b1, s);
        chk(s == e, req, s, e);
        lock_i = ~lock_i; port_in = port_in + 3'd3; adc_code = adc_code ^ 3'd5;
        e = {por_exp, lock_i, port_in, adc_code};
        read_byte(1'b0, s);
        chk(s == e, "R6 second status after master ACK", s, e);
        repeat (6) @(negedge clk);
        chk(sda_oe == 1'b0, "R6 release after NACK", sda_oe, 0);
        i2c_stop();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        bit a;
        logic [14:0] d;
        bit hit;

        lock_i = 1'b1; port_in = 3'b101; adc_code = 3'b011;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8 reset state
        check_regs("R8 reset");
        chk(sda_oe == 1'b0, "R8 sda released", sda_oe, 0);

        // R7 power-on flag set after reset, cleared by read STOP; R6 status
        read_status(1'b1, "R6 status with por set R7");
        read_status(1'b0, "R7 por cleared after read stop");

        // R1 address sweep over select codes and neighbouring bytes
        for (int sel = 0; sel < 4; sel++) begin
            addr_sel = 2'(sel);
            for (int ab = 8'hBE; ab <= 8'hCE; ab += 2) begin
                hit = (ab / 8 == 24) && (((ab / 2) % 4 == 1) || ((ab / 2) % 4 == sel));
                i2c_start();
                write_byte(8'(ab), a);
                chk(a == hit, "R1 address ack", a, hit);
                d = 15'((ab * 37 + sel * 1000 + 5) % 32768);
                wr_div_pair(d, hit);
                i2c_stop();
                chk(divider == exp_div, "R1 divider after address", divider, exp_div);
            end
        end
        addr_sel = 2'd0;

        // R3 divider corners; output holds until second byte
        foreach (d_list[i]) begin
            i2c_start();
            write_byte(8'hC2, a);
            write_byte({1'b0, d_list[i][14:8]}, a);
            repeat (4) @(negedge clk);
            chk(divider == exp_div, "R3 hold after first byte", divider, exp_div);
            write_byte(d_list[i][7:0], a);
            exp_div = d_list[i];
            chk(divider == exp_div, "R3 divider update", divider, exp_div);
            i2c_stop();
        end

        // R4 control pair; port byte bits 7..4 ignored; port byte taken whatever its bit 7
        i2c_start();
        write_byte(8'hC0, a);
        chk(a, "R1 select 0 address", a, 1);
        write_byte(8'hD5, a);
        exp_ctl = 7'h55;
        chk(ctrl == exp_ctl, "R4 ctrl after first byte", ctrl, exp_ctl);
        write_byte(8'hF6, a);
        exp_prt = 4'h6;
        check_regs("R4 port byte with bit 7 set");
        write_byte(8'hAA, a);
        exp_ctl = 7'h2A;
        write_byte(8'h09, a);
        exp_prt = 4'h9;
        check_regs("R4 port byte with bit 7 clear");
        // R5 divider pair after control pair, same transfer
        wr_div_pair(15'h1234, 1'b1);
        write_byte(8'h81, a);
        exp_ctl = 7'h01;
        write_byte(8'h0F, a);
        exp_prt = 4'hF;
        wr_div_pair(15'h6ACE, 1'b1);
        check_regs("R5 mixed pairs one transfer");
        i2c_stop();

        // R5 STOP abandons half pair
        i2c_start();
        write_byte(8'hC2, a);
        write_byte(8'h11, a);
        i2c_stop();
        i2c_start();
        write_byte(8'hC2, a);
        write_byte(8'hBC, a);
        exp_ctl = 7'h3C;
        check_regs("R5 new pair after stop");
        write_byte(8'h03, a);
        exp_prt = 4'h3;
        check_regs("R5 partner of new pair");
        i2c_stop();

        // R9 START within a data byte
        i2c_start();
        write_byte(8'hC2, a);
        write_byte(8'h22, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        repeat (4) @(negedge clk);
        check_regs("R9 partial byte no effect");
        i2c_start();
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R9 released at start", sda_oe, 0);
        write_byte(8'hC2, a);
        chk(a, "R9 re-address ack", a, 1);
        write_byte(8'h9E, a);
        exp_ctl = 7'h1E;
        write_byte(8'h00, a);
        exp_prt = 4'h0;
        check_regs("R9 fresh pair after restart");
        i2c_stop();

        // R7 write transfer leaves flag set
        @(negedge clk); por_event = 1'b1;
        @(negedge clk); por_event = 1'b0;
        i2c_start();
        write_byte(8'hC2, a);
        wr_div_pair(15'h0777, 1'b1);
        i2c_stop();
        read_status(1'b1, "R7 por kept through write stop");
        read_status(1'b0, "R7 por cleared again");

        finish_run();
    end

    logic [14:0] d_list [5] = '{15'h0000, 15'h7FFF, 15'h4000, 15'h00FF, 15'h5555};

endmodule